// File: doc/BRIEF.md
# TLB Maintenance Register Interface

This block is the register layer software uses to maintain a translation lookaside buffer whose entries are loaded by software. It holds an index register that selects one entry slot, two access windows onto that slot (a tag word and a data word), a process-ID register, a zone-protection register and a search command. Accesses arrive as a register number with write and read strobes. Read data is combinational from the current state. Every write, and every read side effect, takes effect at the next rising clock edge.

Each entry stores a tag word, a data word and an 8-bit translation ID. Writing the tag window stamps the entry with the current process ID. Reading the tag window copies that entry's ID back into the process-ID register, so that software can save and restore entries whole. A write to the search register sends its page-number bits to an external matcher. The matcher's hit and index come back in the same cycle and update the index register. Some changes make cached translations stale. When one happens the block sends a one-cycle invalidation request, tagged as covering either all entries or only the written slot.

Top module: `tlb_regif`

## Requirements
- R1: After reset, every register reads zero, every entry's tag, data and ID are zero, and `flush_req` is low.
- R2: Register numbers on `reg_sel` are 0 index, 1 tag, 2 data, 3 process ID, 4 zone and 5 search. Numbers 6 and 7 read zero and ignore writes. The slot used for tag and data access is bits [7:0] of the index register. A slot at or above ENTRIES ignores tag and data writes, and reads of those windows return zero.
- R3: A tag write to a valid slot stores `wdata` as the tag and loads the slot's ID from the process-ID register. In the next cycle it raises `flush_req` for one cycle, with `flush_all`=0 and `flush_idx` set to the slot.
- R4: A data write to a valid slot stores `wdata`, and a later data read of that slot returns it. The index register reads and writes as a full 32-bit word.
- R5: A tag read returns the slot's tag. At the clock edge it also replaces the process-ID register with the slot's ID.
- R6: A search write drives `lk_req` high, with `lk_vpn` = `wdata` & VPN_MASK and `lk_user` = `user_mode`. On `lk_hit` the index register becomes `lk_idx` zero-extended. On a miss, bit 31 of the index register is set and its other bits are kept.
- R7: Writes to the process-ID, zone and search registers take effect only when `acc_level` is 2 or 3. Otherwise they change nothing and `lk_req` stays low.
- R8: Reads of the tag, data, process-ID and zone registers return zero unless `acc_level` bit 0 is set. A tag read blocked this way leaves the process-ID register unchanged.
- R9: When `mmu_mode` is below 2 or `acc_level` is 0, every read returns zero and every write and read side effect is ignored.
- R10: A process-ID write whose low 8 bits differ from the stored value, or a zone write whose value differs from the stored value, raises `flush_req` with `flush_all`=1 for one cycle. A write of an unchanged value raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmu_mode | input | 2 | Configured MMU mode; 2 and 3 enable the interface |
| acc_level | input | 2 | Configured access level for maintenance registers |
| user_mode | input | 1 | Current privilege, 1 = user |
| reg_sel | input | 3 | Register number |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; triggers read side effects when wr_en is low |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for reg_sel |
| lk_req | output | 1 | Search lookup request |
| lk_vpn | output | 32 | Page-number bits to search |
| lk_user | output | 1 | Privilege of the search |
| lk_hit | input | 1 | Lookup hit |
| lk_idx | input | IDX_W | Index of the matching entry |
| flush_req | output | 1 | One-cycle invalidation request |
| flush_all | output | 1 | 1 = all entries, 0 = flush_idx only |
| flush_idx | output | IDX_W | Slot to invalidate |

## Verification
Random streams mix every register number with both strobes. Index values run past ENTRIES, so in-range and out-of-range slots are both reached. Mode and access level change at random, which separates the enable gate, the read gate and the write gate. Search writes get random hit and miss answers. A miss, which sets bit 31 and keeps the other bits, is told apart from a hit, which replaces the whole word. Directed cases write unchanged process-ID and zone values to show that no flush is raised, and do a tag write then tag read across different process IDs to show the ID moving both ways.

// File: rtl/tlb_regif_pkg.sv
package tlb_regif_pkg;

    typedef enum logic [2:0] {
        SEL_INDEX  = 3'd0,
        SEL_TAG    = 3'd1,
        SEL_DATA   = 3'd2,
        SEL_PID    = 3'd3,
        SEL_ZONE   = 3'd4,
        SEL_SEARCH = 3'd5
    } reg_sel_e;

    localparam int WORD_W = 32;
    localparam int TID_W  = 8;
    localparam int SLOT_W = 8;

    typedef struct packed {
        logic enabled;
        logic rd_ok;
        logic wr_priv;
    } gate_t;

endpackage

// File: rtl/tlb_regif_gate.sv
module tlb_regif_gate
    import tlb_regif_pkg::*;
(
    input  logic [1:0] mmu_mode,
    input  logic [1:0] acc_level,
    output gate_t      gate
);
    always_comb begin
        gate.enabled = (mmu_mode >= 2'd2) && (acc_level != 2'd0);
        gate.rd_ok   = gate.enabled && acc_level[0];
        gate.wr_priv = gate.enabled && (acc_level > 2'd1);
    end
endmodule

// File: rtl/tlb_regif_store.sv
module tlb_regif_store
    import tlb_regif_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_tag,
    input  logic              we_data,
    input  logic [IDX_W-1:0]  slot,
    input  logic [WORD_W-1:0] wval,
    input  logic [TID_W-1:0]  wtid,
    output logic [WORD_W-1:0] rtag,
    output logic [WORD_W-1:0] rdat,
    output logic [TID_W-1:0]  rtid
);
    logic [WORD_W-1:0] tag_q  [ENTRIES];
    logic [WORD_W-1:0] dat_q  [ENTRIES];
    logic [TID_W-1:0]  tid_q  [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic [WORD_W-1:0] tag_d, dat_d;
        logic [TID_W-1:0]  tid_d;
        logic              hit_slot;

        always_comb begin
            hit_slot = (slot == IDX_W'(e));
            tag_d    = tag_q[e];
            dat_d    = dat_q[e];
            tid_d    = tid_q[e];
            if (hit_slot && we_tag) begin
                tag_d = wval;
                tid_d = wtid;
            end
            if (hit_slot && we_data) begin
                dat_d = wval;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[e] <= '0;
                dat_q[e] <= '0;
                tid_q[e] <= '0;
            end else begin
                tag_q[e] <= tag_d;
                dat_q[e] <= dat_d;
                tid_q[e] <= tid_d;
            end
        end
    end

    always_comb begin
        rtag = tag_q[slot];
        rdat = dat_q[slot];
        rtid = tid_q[slot];
    end

    // R3
    tag_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_tag |=> (tag_q[$past(slot)] == $past(wval)) && (tid_q[$past(slot)] == $past(wtid)));
endmodule

// File: rtl/tlb_regif_ctrl.sv
module tlb_regif_ctrl
    import tlb_regif_pkg::*;
#(
    parameter int              ENTRIES  = 16,
    parameter logic [31:0]     VPN_MASK = 32'hFFFF_FC00,
    localparam int             IDX_W    = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  gate_t             gate,
    input  logic              user_mode,
    input  logic [2:0]        reg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              lk_req,
    output logic [WORD_W-1:0] lk_vpn,
    output logic              lk_user,
    input  logic              lk_hit,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              flush_req,
    output logic              flush_all,
    output logic [IDX_W-1:0]  flush_idx,
    output logic              st_we_tag,
    output logic              st_we_data,
    output logic [IDX_W-1:0]  st_slot,
    output logic [TID_W-1:0]  st_wtid,
    input  logic [WORD_W-1:0] st_rtag,
    input  logic [WORD_W-1:0] st_rdat,
    input  logic [TID_W-1:0]  st_rtid
);
    typedef struct packed {
        logic [WORD_W-1:0] index;
        logic [TID_W-1:0]  pid;
        logic [WORD_W-1:0] zone;
        logic              fl_req;
        logic              fl_all;
        logic [IDX_W-1:0]  fl_idx;
    } state_t;

    state_t st_d, st_q;

    logic [SLOT_W-1:0] slot_raw;
    logic              slot_ok;
    logic              wr_act, rd_act;

    always_comb begin
        slot_raw = st_q.index[SLOT_W-1:0];
        slot_ok  = ({1'b0, slot_raw} < 9'(ENTRIES));
        wr_act   = wr_en && gate.enabled;
        rd_act   = rd_en && !wr_en && gate.enabled;
        st_slot  = slot_raw[IDX_W-1:0];
        st_wtid  = st_q.pid;
    end

    // read mux
    always_comb begin
        rdata = '0;
        if (gate.enabled) begin
            unique case (reg_sel)
                SEL_INDEX: rdata = st_q.index;
                SEL_TAG:   rdata = (gate.rd_ok && slot_ok) ? st_rtag : '0;
                SEL_DATA:  rdata = (gate.rd_ok && slot_ok) ? st_rdat : '0;
                SEL_PID:   rdata = gate.rd_ok ? WORD_W'(st_q.pid) : '0;
                SEL_ZONE:  rdata = gate.rd_ok ? st_q.zone : '0;
                default:   rdata = '0;
            endcase
        end
    end

    // next state
    always_comb begin
        st_d        = st_q;
        st_d.fl_req = 1'b0;
        st_d.fl_all = 1'b0;
        st_d.fl_idx = '0;
        st_we_tag   = 1'b0;
        st_we_data  = 1'b0;
        lk_req      = 1'b0;
        lk_vpn      = wdata & VPN_MASK;
        lk_user     = user_mode;

        if (wr_act) begin
            unique case (reg_sel)
                SEL_INDEX: st_d.index = wdata;
                SEL_TAG: begin
                    if (slot_ok) begin
                        st_we_tag   = 1'b1;
                        st_d.fl_req = 1'b1;
                        st_d.fl_idx = slot_raw[IDX_W-1:0];
                    end
                end
                SEL_DATA: st_we_data = slot_ok;
                SEL_PID: begin
                    if (gate.wr_priv && (wdata[TID_W-1:0] != st_q.pid)) begin
                        st_d.pid    = wdata[TID_W-1:0];
                        st_d.fl_req = 1'b1;
                        st_d.fl_all = 1'b1;
                    end
                end
                SEL_ZONE: begin
                    if (gate.wr_priv && (wdata != st_q.zone)) begin
                        st_d.zone   = wdata;
                        st_d.fl_req = 1'b1;
                        st_d.fl_all = 1'b1;
                    end
                end
                SEL_SEARCH: begin
                    if (gate.wr_priv) begin
                        lk_req = 1'b1;
                        if (lk_hit) begin
                            st_d.index = {{(WORD_W-IDX_W){1'b0}}, lk_idx};
                        end else begin
                            st_d.index = st_q.index | 32'h8000_0000;
                        end
                    end
                end
                default: ;
            endcase
        end else if (rd_act && reg_sel == SEL_TAG && gate.rd_ok && slot_ok) begin
            st_d.pid = st_rtid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        flush_req = st_q.fl_req;
        flush_all = st_q.fl_all;
        flush_idx = st_q.fl_idx;
    end

    // R9
    disabled_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate.enabled |=> $stable(st_q.index) && $stable(st_q.pid) && $stable(st_q.zone) && !flush_req);

    // R9
    always_comb begin
        if (rst_n && !gate.enabled) disabled_reads_zero_chk: assert (rdata == '0);
    end

    // R7
    lookup_needs_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> gate.wr_priv && wr_en && (reg_sel == SEL_SEARCH));

    // R6
    search_miss_sets_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !lk_hit) |=> st_q.index[31] && (st_q.index[30:0] == $past(st_q.index[30:0])));

    // R10
    flush_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> $past(wr_en) && $past(gate.enabled));

    // R8
    blocked_tag_read_keeps_pid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !gate.rd_ok) |=> $stable(st_q.pid));
endmodule

// File: rtl/tlb_regif.sv
module tlb_regif
    import tlb_regif_pkg::*;
#(
    parameter int          ENTRIES  = 16,
    parameter logic [31:0] VPN_MASK = 32'hFFFF_FC00,
    localparam int         IDX_W    = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mmu_mode,
    input  logic [1:0]       acc_level,
    input  logic             user_mode,
    input  logic [2:0]       reg_sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             lk_req,
    output logic [31:0]      lk_vpn,
    output logic             lk_user,
    input  logic             lk_hit,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             flush_req,
    output logic             flush_all,
    output logic [IDX_W-1:0] flush_idx
);
    gate_t             gate;
    logic              we_tag, we_data;
    logic [IDX_W-1:0]  slot;
    logic [TID_W-1:0]  wtid, rtid;
    logic [WORD_W-1:0] rtag, rdat;

    tlb_regif_gate u_gate (
        .mmu_mode  (mmu_mode),
        .acc_level (acc_level),
        .gate      (gate)
    );

    tlb_regif_store #(.ENTRIES(ENTRIES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_tag  (we_tag),
        .we_data (we_data),
        .slot    (slot),
        .wval    (wdata),
        .wtid    (wtid),
        .rtag    (rtag),
        .rdat    (rdat),
        .rtid    (rtid)
    );

    tlb_regif_ctrl #(.ENTRIES(ENTRIES), .VPN_MASK(VPN_MASK)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate       (gate),
        .user_mode  (user_mode),
        .reg_sel    (reg_sel),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wdata      (wdata),
        .rdata      (rdata),
        .lk_req     (lk_req),
        .lk_vpn     (lk_vpn),
        .lk_user    (lk_user),
        .lk_hit     (lk_hit),
        .lk_idx     (lk_idx),
        .flush_req  (flush_req),
        .flush_all  (flush_all),
        .flush_idx  (flush_idx),
        .st_we_tag  (we_tag),
        .st_we_data (we_data),
        .st_slot    (slot),
        .st_wtid    (wtid),
        .st_rtag    (rtag),
        .st_rdat    (rdat),
        .st_rtid    (rtid)
    );

    // R3
    tag_flush_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_all) |-> $past(reg_sel) == 3'd1);
endmodule

// File: tb/tlb_regif_test.sv
module tlb_regif_test;
    localparam int CLK_P   = 10;
    localparam int ENTRIES = 16;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam logic [31:0] MASK = 32'hFFFF_FC00;

    logic clk = 0, rst_n = 0;
    logic [1:0] mmu_mode = 2'd3, acc_level = 2'd3;
    logic user_mode = 0;
    logic [2:0] reg_sel = 0;
    logic wr_en = 0, rd_en = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic lk_req, lk_user, lk_hit = 0;
    logic [31:0] lk_vpn;
    logic [IDX_W-1:0] lk_idx = 0;
    logic flush_req, flush_all;
    logic [IDX_W-1:0] flush_idx;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [31:0] m_tag [ENTRIES];
    logic [31:0] m_dat [ENTRIES];
    logic [7:0]  m_tid [ENTRIES];
    logic [31:0] m_index, m_zone;
    logic [7:0]  m_pid;

    always #(CLK_P/2) clk = ~clk;

    tlb_regif #(.ENTRIES(ENTRIES), .VPN_MASK(MASK)) uut (
        .clk(clk), .rst_n(rst_n), .mmu_mode(mmu_mode), .acc_level(acc_level),
        .user_mode(user_mode), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .lk_req(lk_req), .lk_vpn(lk_vpn),
        .lk_user(lk_user), .lk_hit(lk_hit), .lk_idx(lk_idx),
        .flush_req(flush_req), .flush_all(flush_all), .flush_idx(flush_idx)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit en_f();
        return (mmu_mode >= 2) && (acc_level != 0);
    endfunction

    function automatic bit slot_ok_f();
        return m_index[7:0] < ENTRIES;
    endfunction

    function automatic logic [31:0] exp_read(logic [2:0] sel);
        if (!en_f()) return 0;
        case (sel)
            3'd0: return m_index;
            3'd1: return (acc_level[0] && slot_ok_f()) ? m_tag[m_index[IDX_W-1:0]] : 0;
            3'd2: return (acc_level[0] && slot_ok_f()) ? m_dat[m_index[IDX_W-1:0]] : 0;
            3'd3: return acc_level[0] ? {24'd0, m_pid} : 0;
            3'd4: return acc_level[0] ? m_zone : 0;
            default: return 0;
        endcase
    endfunction

    // one write; checks lookup outputs before the edge and flush after it
    task automatic do_write(logic [2:0] sel, logic [31:0] v, bit hit, logic [IDX_W-1:0] hidx);
        bit e_fl, e_all, e_lk;
        logic [IDX_W-1:0] e_idx;
        @(negedge clk);
        reg_sel = sel; wdata = v; wr_en = 1; rd_en = $urandom_range(0, 1);
        lk_hit = hit; lk_idx = hidx;
        e_fl = 0; e_all = 0; e_lk = 0; e_idx = 0;
        #(CLK_P/4);
        if (en_f()) begin
            case (sel)
                3'd0: m_index = v;
                3'd1: if (slot_ok_f()) begin
                    m_tag[m_index[IDX_W-1:0]] = v;
                    m_tid[m_index[IDX_W-1:0]] = m_pid;
                    e_fl = 1; e_idx = m_index[IDX_W-1:0];
                end
                3'd2: if (slot_ok_f()) m_dat[m_index[IDX_W-1:0]] = v;
                3'd3: if (acc_level > 1 && v[7:0] != m_pid) begin
                    m_pid = v[7:0]; e_fl = 1; e_all = 1;
                end
                3'd4: if (acc_level > 1 && v != m_zone) begin
                    m_zone = v; e_fl = 1; e_all = 1;
                end
                3'd5: if (acc_level > 1) begin
                    e_lk = 1;
                    m_index = hit ? {{(32-IDX_W){1'b0}}, hidx} : (m_index | 32'h8000_0000);
                end
                default: ;
            endcase
        end
        check("R7 lk_req", {31'd0, lk_req}, {31'd0, e_lk});
        if (e_lk) begin
            check("R6 lk_vpn", lk_vpn, v & MASK);
            check("R6 lk_user", {31'd0, lk_user}, {31'd0, user_mode});
        end
        @(posedge clk);
        #(CLK_P/4);
        wr_en = 0; rd_en = 0;
        check("R10 flush_req", {31'd0, flush_req}, {31'd0, e_fl});
        if (e_fl) begin
            check("R10 flush_all", {31'd0, flush_all}, {31'd0, e_all});
            if (!e_all) check("R3 flush_idx", {{(32-IDX_W){1'b0}}, flush_idx}, {{(32-IDX_W){1'b0}}, e_idx});
        end
    endtask

    task automatic do_read(logic [2:0] sel, string req);
        @(negedge clk);
        reg_sel = sel; rd_en = 1; wr_en = 0;
        #(CLK_P/4);
        check(req, rdata, exp_read(sel));
        if (sel == 3'd1 && en_f() && acc_level[0] && slot_ok_f())
            m_pid = m_tid[m_index[IDX_W-1:0]];
        @(posedge clk);
        #(CLK_P/4);
        rd_en = 0;
        check("R5 no flush on read", {31'd0, flush_req}, 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < ENTRIES; i++) begin
            m_tag[i] = 0; m_dat[i] = 0; m_tid[i] = 0;
        end
        m_index = 0; m_zone = 0; m_pid = 0;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        check("R1 flush after reset", {31'd0, flush_req}, 32'd0);
        rst_n = 1;
        for (int s = 0; s < 8; s++) do_read(3'(s), "R1 reset read");

        // R4 index and data round trip
        do_write(3'd0, 32'h0000_0003, 0, 0);
        do_read(3'd0, "R4 index read");
        do_write(3'd2, 32'hCAFE_F00D, 0, 0);
        do_read(3'd2, "R4 data read");
        // R3 / R5: tag stamped with pid 0x21, read back under pid 0x55
        do_write(3'd3, 32'h0000_0021, 0, 0);
        do_write(3'd1, 32'h1234_5840, 0, 0);
        do_write(3'd3, 32'h0000_0055, 0, 0);
        do_read(3'd1, "R5 tag read");
        do_read(3'd3, "R5 pid loaded from tid");
        // R10 unchanged values: no flush
        do_write(3'd3, 32'hFFFF_FF21, 0, 0);
        do_write(3'd4, 32'hA5A5_0000, 0, 0);
        do_write(3'd4, 32'hA5A5_0000, 0, 0);
        // R2 out-of-range slot
        do_write(3'd0, 32'h0000_0013, 0, 0);
        do_write(3'd1, 32'hDEAD_BEEF, 0, 0);
        do_read(3'd1, "R2 out-of-range tag");
        do_read(3'd6, "R2 unused number");
        // R6 miss then hit
        do_write(3'd5, 32'h8765_4321, 0, 0);
        do_read(3'd0, "R6 miss index");
        do_write(3'd5, 32'h0000_2000, 1, 4'd9);
        do_read(3'd0, "R6 hit index");
        // R7 / R8 level 1: privileged writes ignored, reads allowed
        acc_level = 2'd1;
        do_write(3'd4, 32'h0F0F_0F0F, 0, 0);
        do_write(3'd5, 32'h0000_0000, 0, 0);
        do_read(3'd4, "R7 zone unchanged");
        // R8 level 2: reads gated
        acc_level = 2'd2;
        do_read(3'd3, "R8 pid read gated");
        do_read(3'd1, "R8 tag read gated");
        acc_level = 2'd3;
        do_read(3'd3, "R8 pid kept after gated tag read");
        // R9 disabled
        mmu_mode = 2'd1;
        do_write(3'd0, 32'h0000_0001, 0, 0);
        do_read(3'd0, "R9 disabled read");
        mmu_mode = 2'd3;
        do_read(3'd0, "R9 index unchanged");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] sel;
            logic [31:0] v;
            if ($urandom_range(0, 15) == 0) mmu_mode = 2'($urandom_range(0, 3));
            else if ($urandom_range(0, 7) == 0) mmu_mode = 2'd3;
            if ($urandom_range(0, 15) == 0) acc_level = 2'($urandom_range(0, 3));
            else if ($urandom_range(0, 7) == 0) acc_level = 2'd3;
            user_mode = 1'($urandom_range(0, 1));
            sel = 3'($urandom_range(0, 7));
            v = $urandom();
            if (sel == 3'd0) v = $urandom_range(0, 19);
            if (sel == 3'd3 && $urandom_range(0, 1) == 1) v = {24'd0, m_pid};
            if ($urandom_range(0, 1) == 1)
                do_write(sel, v, 1'($urandom_range(0, 1)), IDX_W'($urandom_range(0, ENTRIES-1)));
            else
                do_read(sel, "R2 R4 R5 R8 R9 random read");
        end
        finish_run();
    end
endmodule